// File: doc/BRIEF.md
# Power-Mode Peripheral Clock-Enable Controller

This block produces one clock-enable line for every peripheral of a chip, grouped into words of `W` bits. For each group it stores three enable words: one that applies while the processor runs, one for light sleep and one for deep sleep. A small power-mode state machine tracks which of the three modes the device is in, and the enable word of the current mode drives the outputs through a register. The enables therefore change only on clock edges and cannot glitch within a cycle.

Software writes the enable words through a plain write port. Every written word is ANDed with a fixed per-group capability mask, which is set by a parameter. The enable of a peripheral that the device does not have can never be set, and it always reads back as zero. Software enters light or deep sleep with a request pulse that carries a deep flag. Any interrupt brings the device back to Run. While the device is in either sleep mode, the processor clock enable is low.

Top module: `pclk_mode_gate`

## Requirements
- R1: After reset the mode is Run (code 0), all stored enable words are zero, `periph_clk_en` is all zero and `cpu_clk_en` is 1.
- R2: A write stores `wr_data` ANDed with the capability mask of the addressed group. Address layout: `addr[1:0]` selects the bank (0 Run, 1 Sleep, 2 Deep-Sleep) and the bits above select the group.
- R3: At each rising edge `periph_clk_en` loads the bank selected by the mode value held before that edge. A write made in Run therefore reaches the outputs on the second edge after the write cycle.
- R4: In Run, `sleep_req` without `irq` moves the mode to Sleep (code 1) on the next edge when `sleep_deep` is 0, and to Deep-Sleep (code 2) when it is 1.
- R5: One edge after the mode changes to Sleep or Deep-Sleep, `periph_clk_en` equals that mode's bank.
- R6: `irq` in Sleep or Deep-Sleep returns the mode to Run on the next edge.
- R7: When `irq` and `sleep_req` are high in the same cycle in Run, the mode stays Run.
- R8: `sleep_req` while in Sleep or Deep-Sleep has no effect on the mode.
- R9: `cpu_clk_en` is 1 in Run and 0 in both sleep modes.
- R10: `rd_data` returns the masked stored word of the addressed bank and group, whatever the current mode. Bank code 3 and out-of-range groups read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address {group, bank} |
| wr_data | input | W | Write data |
| rd_addr | input | AW | Read address {group, bank} |
| rd_data | output | W | Masked stored word, combinational |
| sleep_req | input | 1 | Software sleep request |
| sleep_deep | input | 1 | Selects Deep-Sleep with a request |
| irq | input | 1 | Any pending interrupt |
| mode | output | 2 | Current mode: 0 Run, 1 Sleep, 2 Deep-Sleep |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NGRP*W | Registered per-peripheral clock enables |

## Verification
The assertions assume that `sleep_deep` is meaningful only in a cycle where `sleep_req` is high, and that the mode code 3 can never be reached from the inputs. They also assume that the capability mask is fixed for the whole run. The bench drives every input at the falling edge and holds requests for exactly one cycle. It raises the `irq`-with-request collision only in Run, and it writes the reserved bank code only when the resulting words are compared at the read port afterwards.

// File: rtl/pclk_mode_gate.sv
module pclk_mode_gate #(
  parameter int NGRP = 2,
  parameter int W = 32,
  parameter logic [NGRP*W-1:0] CAP_MASK = {32'h0F0F_3C01, 32'h0000_F0FF},
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int AW = GW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic            sleep_req,
  input  logic            sleep_deep,
  input  logic            irq,
  output logic [1:0]      mode,
  output logic            cpu_clk_en,
  output logic [NGRP*W-1:0] periph_clk_en
);
  localparam logic [1:0] M_RUN = 2'd0, M_SLP = 2'd1, M_DSLP = 2'd2;

  logic [W-1:0] run_q [NGRP];
  logic [W-1:0] slp_q [NGRP];
  logic [W-1:0] dslp_q[NGRP];
  logic [1:0]   mode_d;

  wire [GW-1:0] wr_grp = wr_addr[AW-1:2];
  wire [GW-1:0] rd_grp = rd_addr[AW-1:2];

  always_comb begin
    mode_d = mode;
    if (irq) mode_d = M_RUN;
    else if (mode == M_RUN && sleep_req) mode_d = sleep_deep ? M_DSLP : M_SLP;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= M_RUN;
    else        mode <= mode_d;

  assign cpu_clk_en = (mode == M_RUN);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wire [W-1:0] cap = CAP_MASK[g*W +: W];
    wire hit = wr_en && (wr_grp == GW'(g));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_q[g]  <= '0;
        slp_q[g]  <= '0;
        dslp_q[g] <= '0;
      end else if (hit) begin
        case (wr_addr[1:0])
          2'd0: run_q[g]  <= wr_data & cap;
          2'd1: slp_q[g]  <= wr_data & cap;
          2'd2: dslp_q[g] <= wr_data & cap;
          default: ;
        endcase
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) periph_clk_en[g*W +: W] <= '0;
      else case (mode)
        M_SLP:   periph_clk_en[g*W +: W] <= slp_q[g];
        M_DSLP:  periph_clk_en[g*W +: W] <= dslp_q[g];
        default: periph_clk_en[g*W +: W] <= run_q[g];
      endcase
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NGRP; g++)
      if (rd_grp == GW'(g))
        case (rd_addr[1:0])
          2'd0: rd_data = run_q[g];
          2'd1: rd_data = slp_q[g];
          2'd2: rd_data = dslp_q[g];
          default: rd_data = '0;
        endcase
  end

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_clk_en & ~CAP_MASK) == '0); // R2
  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && sleep_req && !irq) |=> (mode == ($past(sleep_deep) ? M_DSLP : M_SLP))); // R4
  AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> mode == M_RUN); // R6
  AST_IRQ_BEATS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && sleep_req && irq) |=> mode == M_RUN); // R7
  AST_ASLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_RUN && !irq) |=> $stable(mode)); // R8
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_RUN) |-> !cpu_clk_en); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R1
endmodule

// File: tb/pclk_mode_gate_tb.sv
`timescale 1ns/1ps
module pclk_mode_gate_tb;
  localparam int NGRP = 2, W = 32, AW = 3;
  localparam logic [63:0] MASK = {32'h0F0F_3C01, 32'h0000_F0FF};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, sleep_req = 0, sleep_deep = 0, irq = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [1:0] mode;
  logic cpu_clk_en;
  logic [63:0] periph_clk_en;
  int checks = 0, fails = 0;
  logic [W-1:0] mdl [3][NGRP];

  always #2.5 clk = ~clk;

  pclk_mode_gate u_dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .sleep_req, .sleep_deep, .irq, .mode, .cpu_clk_en, .periph_clk_en);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] bankv(int b);
    return {mdl[b][1], mdl[b][0]};
  endfunction

  task automatic wr(int b, int g, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {g[0], b[1:0]}; wr_data = d;
    if (b < 3) mdl[b][g] = d & MASK[g*W +: W];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic req(logic deep, logic with_irq);
    @(negedge clk);
    sleep_req = 1; sleep_deep = deep; irq = with_irq;
    @(negedge clk);
    sleep_req = 0; sleep_deep = 0; irq = 0;
  endtask

  task automatic wake();
    @(negedge clk); irq = 1;
    @(negedge clk); irq = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 en", periph_clk_en, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    for (int b = 0; b < 3; b++) begin
      rd_addr = {1'b0, 2'(b)}; #0.1; chk("R1 bank g0", rd_data, 0);
      rd_addr = {1'b1, 2'(b)}; #0.1; chk("R1 bank g1", rd_data, 0);
    end
  endtask

  task automatic t_write_mask();
    wr(0, 0, 32'hFFFF_FFFF);
    wr(0, 1, 32'hFFFF_FFFF);
    wr(1, 0, 32'h1234_5678);
    wr(1, 1, 32'hA5A5_A5A5);
    wr(2, 0, 32'h0000_8001);
    wr(2, 1, 32'h0101_0101);
    for (int b = 0; b < 3; b++)
      for (int g = 0; g < 2; g++) begin
        rd_addr = {g[0], 2'(b)}; #0.1;
        chk("R2 masked store", rd_data, mdl[b][g]);
      end
  endtask

  task automatic t_run_timing();
    wr(0, 0, 32'h0000_00F0);
    chk("R3 one edge after write", periph_clk_en, {mdl[0][1], 32'h0000_F0FF});
    @(negedge clk);
    chk("R3 two edges after write", periph_clk_en, bankv(0));
  endtask

  task automatic t_sleep(logic deep);
    int b = deep ? 2 : 1;
    req(deep, 0);
    chk("R4 mode entry", mode, b);
    chk("R9 cpu off", cpu_clk_en, 0);
    chk("R5 enables lag", periph_clk_en, bankv(0));
    @(negedge clk);
    chk("R5 sleep bank", periph_clk_en, bankv(b));
    req(~deep, 0);
    chk("R8 request ignored", mode, b);
    rd_addr = {1'b1, 2'd0}; #0.1;
    chk("R10 read in sleep", rd_data, mdl[0][1]);
    wake();
    chk("R6 irq wakes", mode, 0);
    chk("R9 cpu on", cpu_clk_en, 1);
    @(negedge clk);
    chk("R3 run bank back", periph_clk_en, bankv(0));
  endtask

  task automatic t_collision();
    req(1, 1);
    chk("R7 irq wins", mode, 0);
    req(0, 1);
    chk("R7 irq wins light", mode, 0);
  endtask

  task automatic t_reserved();
    wr(3, 0, 32'hFFFF_FFFF);
    rd_addr = {1'b0, 2'd3}; #0.1;
    chk("R10 reserved reads zero", rd_data, 0);
    for (int b = 0; b < 3; b++) begin
      rd_addr = {1'b0, 2'(b)}; #0.1;
      chk("R10 reserved write no effect", rd_data, mdl[b][0]);
    end
  endtask

  initial begin
    fork
      begin
        for (int b = 0; b < 3; b++) for (int g = 0; g < 2; g++) mdl[b][g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_run_timing();
        t_sleep(0);
        t_sleep(1);
        t_collision();
        t_reserved();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule